// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a functional clock into the bit-level timing of an I2C master. A byte engine sits above it and issues three kinds of request: open a transfer with a START (or a repeated START), move one bit, or close with a STOP. The block drives the SCL and SDA open-drain pull-downs. It also emits single-cycle strobes that tell the engine when START and STOP have been placed on the bus, when SDA has changed, and when SDA can be sampled.

All timing comes from a power-of-two prescaler and four fields counted in prescaled units: SCL high time, SCL low time, START/STOP setup-and-hold time, and the data-valid delay after the SCL falling edge. The configuration is captured only while the enable is low. With the usual settings (low = 2 × high, setup/hold = high, data-valid = high / 2) one bit period is about 3 × high + 2 units. The high phase is counted only after the SCL line has been seen high, so a slave that holds SCL low stretches the clock.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while enabled with no request pending, both pull-downs are off and no strobe is active. `ready` is high only when `en` is high and the block is idle or waiting between bits with SCL held low.
- R2: The prescaler and timing fields are captured on every clock in which `en` is low. Changes to those inputs while `en` is high have no effect on any later timing.
- R3: One timing unit lasts 2^`cfg_prescale` clock cycles (1 to 128). Each phase of N units lasts exactly N × 2^`cfg_prescale` cycles from the edge that starts it.
- R4: A START taken while idle releases both lines and waits for SCL to be seen high. After setup/hold units it pulls SDA low and pulses `stb_start`. After setup/hold more units it pulls SCL low and becomes ready.
- R5: A bit request taken while ready pulls SCL low for the low-time units. Data-valid units into that low phase, SDA is set (pulled low for `bit_val`=0, released for 1) and `stb_sda_chg` pulses. SCL is then released and, once seen high, held high for the high-time units before it is pulled low again. At most one strobe is active in any cycle.
- R6: The high-phase count starts only in the cycle after a registered sample of `scl_in` reads high. `stb_sample` pulses in that first counted cycle, and only for a bit request.
- R7: A START taken while ready (repeated START) releases SDA at the data-valid point of a low phase, releases SCL at its end, and then follows the R4 sequence from the wait for SCL high.
- R8: A STOP taken while ready pulls SDA low at the data-valid point of a low phase and releases SCL at its end. Once SCL is seen high, it counts setup/hold units, then releases SDA, pulses `stb_stop` and returns to idle.
- R9: Requests are taken only while `ready` is high. In idle only a START is taken. If several requests arrive together, START wins over STOP and STOP wins over a bit.
- R10: With `en` low, the block returns to idle on the next clock and releases both lines, aborting any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable; low allows configuration and forces idle |
| cfg_prescale | input | 3 | Prescaler exponent n, divisor 2^n |
| cfg_high | input | 6 | SCL high time in units |
| cfg_low | input | 6 | SCL low time in units |
| cfg_sethold | input | 6 | START/STOP setup and START hold time in units |
| cfg_dvalid | input | 6 | Delay from SCL low to SDA change in units |
| cmd_start | input | 1 | Request START or repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_bit | input | 1 | Request one bit slot |
| bit_val | input | 1 | Value to place on SDA for a bit slot |
| scl_in | input | 1 | Observed SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |
| ready | output | 1 | A request can be taken this cycle |
| stb_start | output | 1 | START has just been placed on the bus |
| stb_stop | output | 1 | STOP has just been placed on the bus |
| stb_sda_chg | output | 1 | SDA has just been changed in a low phase |
| stb_sample | output | 1 | SCL high counting has begun; SDA may be sampled |

## Verification
The checks assume that whenever the block is enabled, the captured fields are legal. Every field must be non-zero, and the data-valid delay must be strictly shorter than the low time, so the SDA change always falls inside the low phase. The stimulus writes new fields only with `en` low and uses only legal sets, including the one-unit high-time case at the largest prescaler and the widest fields. SCL is driven back to the block as the wired-AND of its own pull-down and a slave stretch signal. The stretch is applied only while SCL is released and waiting to go high, never in the middle of a counted high phase.

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen #(
  parameter int PW = 3,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] cfg_prescale,
  input  logic [TW-1:0] cfg_high,
  input  logic [TW-1:0] cfg_low,
  input  logic [TW-1:0] cfg_sethold,
  input  logic [TW-1:0] cfg_dvalid,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_bit,
  input  logic          bit_val,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic          ready,
  output logic          stb_start,
  output logic          stb_stop,
  output logic          stb_sda_chg,
  output logic          stb_sample
);
  localparam int DW = (1 << PW) - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_LOW, ST_WAITH, ST_HIGH, ST_SHD} state_t;
  typedef enum logic [1:0] {OP_BIT, OP_START, OP_STOP} op_t;

  state_t        state;
  op_t           op;
  logic          bitv, scl_s;
  logic [PW-1:0] pre_q;
  logic [TW-1:0] hi_q, lo_q, sh_q, dv_q;
  logic [DW-1:0] pcnt, pmask;
  logic [TW-1:0] tcnt, lim;
  logic          tick, last, dv_hit, counting, sda_next;

  assign pmask    = ~({DW{1'b1}} << pre_q);
  assign tick     = (pcnt == pmask);
  assign counting = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_SHD);
  assign ready    = en && ((state == ST_HOLD) || (state == ST_IDLE));

  always_comb begin
    lim = sh_q;
    if (state == ST_LOW) lim = lo_q;
    else if (state == ST_HIGH && op == OP_BIT) lim = hi_q;
  end

  assign last   = tick && (tcnt == lim - TW'(1));
  assign dv_hit = tick && (state == ST_LOW) && (tcnt == dv_q - TW'(1));

  always_comb begin
    case (op)
      OP_BIT:   sda_next = ~bitv;
      OP_STOP:  sda_next = 1'b1;
      default:  sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op <= OP_BIT;
      bitv <= 1'b0;
      scl_s <= 1'b0;
      pre_q <= '0;
      hi_q <= TW'(1);
      lo_q <= TW'(3);
      sh_q <= TW'(2);
      dv_q <= TW'(1);
      pcnt <= '0;
      tcnt <= '0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
      stb_start <= 1'b0;
      stb_stop <= 1'b0;
      stb_sda_chg <= 1'b0;
      stb_sample <= 1'b0;
    end else begin
      stb_start <= 1'b0;
      stb_stop <= 1'b0;
      stb_sda_chg <= 1'b0;
      stb_sample <= 1'b0;
      scl_s <= scl_in;
      if (!en) begin
        state <= ST_IDLE;
        scl_drive_low <= 1'b0;
        sda_drive_low <= 1'b0;
        pcnt <= '0;
        tcnt <= '0;
        pre_q <= cfg_prescale;
        hi_q <= cfg_high;
        lo_q <= cfg_low;
        sh_q <= cfg_sethold;
        dv_q <= cfg_dvalid;
      end else begin
        if (counting) begin
          if (tick) begin
            pcnt <= '0;
            tcnt <= tcnt + TW'(1);
          end else begin
            pcnt <= pcnt + DW'(1);
          end
        end
        case (state)
          ST_IDLE: if (cmd_start) begin
            state <= ST_WAITH;
            op <= OP_START;
          end
          ST_HOLD: if (cmd_start || cmd_stop || cmd_bit) begin
            state <= ST_LOW;
            pcnt <= '0;
            tcnt <= '0;
            bitv <= bit_val;
            if (cmd_start) op <= OP_START;
            else if (cmd_stop) op <= OP_STOP;
            else op <= OP_BIT;
          end
          ST_LOW: begin
            if (dv_hit) begin
              sda_drive_low <= sda_next;
              stb_sda_chg <= 1'b1;
            end
            if (last) begin
              state <= ST_WAITH;
              scl_drive_low <= 1'b0;
            end
          end
          ST_WAITH: if (scl_s) begin
            state <= ST_HIGH;
            pcnt <= '0;
            tcnt <= '0;
            stb_sample <= (op == OP_BIT);
          end
          ST_HIGH: if (last) begin
            case (op)
              OP_BIT: begin
                state <= ST_HOLD;
                scl_drive_low <= 1'b1;
              end
              OP_START: begin
                state <= ST_SHD;
                sda_drive_low <= 1'b1;
                stb_start <= 1'b1;
                pcnt <= '0;
                tcnt <= '0;
              end
              default: begin
                state <= ST_IDLE;
                sda_drive_low <= 1'b0;
                stb_stop <= 1'b1;
              end
            endcase
          end
          ST_SHD: if (last) begin
            state <= ST_HOLD;
            scl_drive_low <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (hi_q != 0 && sh_q != 0 && dv_q != 0 && dv_q < lo_q));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_start, stb_stop, stb_sda_chg, stb_sample}));

  // R6
  sample_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_sample |-> $past(scl_s));

  // R4
  start_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_start |-> (sda_drive_low && !scl_drive_low));

  // R8
  stop_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_stop |-> (!sda_drive_low && !scl_drive_low));

  // R7
  rstart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_sda_chg && op == OP_START) |-> !sda_drive_low);

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !sda_drive_low));

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(hi_q) && $stable(lo_q) && $stable(pre_q)));
endmodule

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] cfg_prescale = '0;
  logic [5:0] cfg_high = 6'd1, cfg_low = 6'd3, cfg_sethold = 6'd2, cfg_dvalid = 6'd1;
  logic cmd_start = 0, cmd_stop = 0, cmd_bit = 0, bit_val = 0;
  logic stretch = 0;
  logic scl_in;
  logic scl_drive_low, sda_drive_low, ready, stb_start, stb_stop, stb_sda_chg, stb_sample;

  assign scl_in = !scl_drive_low && !stretch;

  scl_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_prescale(cfg_prescale), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_sethold(cfg_sethold), .cfg_dvalid(cfg_dvalid),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_bit(cmd_bit), .bit_val(bit_val),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ready(ready), .stb_start(stb_start), .stb_stop(stb_stop),
    .stb_sda_chg(stb_sda_chg), .stb_sample(stb_sample)
  );

  always #2.5 clk = ~clk;

  localparam int P_IDLE = 0, P_HOLD = 1, P_LOW = 2, P_WAIT = 3, P_HIGH = 4, P_SHD = 5;
  localparam int K_BIT = 0, K_START = 1, K_STOP = 2;

  int ph = P_IDLE, kind = K_BIT, lt = 0;
  int m_pre = 0, m_hi = 1, m_lo = 3, m_sh = 2, m_dv = 1;
  bit mbit = 0, msync = 0, armed = 0;
  bit e_scl = 0, e_sda = 0, e_start = 0, e_stop = 0, e_chg = 0, e_smp = 0;
  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // Behavioural reference: each phase is a countdown in raw clock cycles.
  always @(posedge clk) begin
    int div;
    bit line;
    line = !e_scl && !stretch;
    e_start = 0; e_stop = 0; e_chg = 0; e_smp = 0;
    if (!rst_n) begin
      ph = P_IDLE; e_scl = 0; e_sda = 0; msync = 0; lt = 0;
      m_pre = 0; m_hi = 1; m_lo = 3; m_sh = 2; m_dv = 1;
    end else begin
      armed = 1;
      div = 1 << m_pre;
      if (!en) begin
        ph = P_IDLE; e_scl = 0; e_sda = 0;
        m_pre = cfg_prescale; m_hi = cfg_high; m_lo = cfg_low;
        m_sh = cfg_sethold; m_dv = cfg_dvalid;
      end else begin
        case (ph)
          P_IDLE: if (cmd_start) begin ph = P_WAIT; kind = K_START; end
          P_HOLD: if (cmd_start || cmd_stop || cmd_bit) begin
            ph = P_LOW; lt = 0; mbit = bit_val;
            kind = cmd_start ? K_START : (cmd_stop ? K_STOP : K_BIT);
          end
          P_LOW: begin
            lt++;
            if (lt == m_dv * div) begin
              e_chg = 1;
              e_sda = (kind == K_BIT) ? !mbit : (kind == K_STOP);
            end
            if (lt == m_lo * div) begin ph = P_WAIT; e_scl = 0; end
          end
          P_WAIT: if (msync) begin ph = P_HIGH; lt = 0; e_smp = (kind == K_BIT); end
          P_HIGH: begin
            lt++;
            if (lt == ((kind == K_BIT) ? m_hi : m_sh) * div) begin
              if (kind == K_BIT) begin ph = P_HOLD; e_scl = 1; end
              else if (kind == K_START) begin ph = P_SHD; e_sda = 1; e_start = 1; lt = 0; end
              else begin ph = P_IDLE; e_sda = 0; e_stop = 1; end
            end
          end
          P_SHD: begin
            lt++;
            if (lt == m_sh * div) begin ph = P_HOLD; e_scl = 1; end
          end
          default: ph = P_IDLE;
        endcase
      end
      msync = line;
    end
  end

  always @(negedge clk) if (armed) begin
    logic [6:0] act, exp;
    act = {scl_drive_low, sda_drive_low, ready, stb_start, stb_stop, stb_sda_chg, stb_sample};
    exp = {e_scl, e_sda, en && (ph == P_HOLD || ph == P_IDLE), e_start, e_stop, e_chg, e_smp};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", cur_req, $time, act, exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic steps(int n);
    repeat (n) step();
  endtask

  task automatic pulse(logic s, logic p, logic b, logic v);
    cmd_start = s; cmd_stop = p; cmd_bit = b; bit_val = v;
    step();
    cmd_start = 0; cmd_stop = 0; cmd_bit = 0;
  endtask

  task automatic wait_ready();
    while (!ready) step();
  endtask

  task automatic configure(int p, int h, int l, int s, int d);
    en = 0; step();
    cfg_prescale = 3'(p); cfg_high = 6'(h); cfg_low = 6'(l);
    cfg_sethold = 6'(s); cfg_dvalid = 6'(d);
    step(); en = 1; step();
  endtask

  task automatic do_start(); pulse(1, 0, 0, 0); wait_ready(); endtask
  task automatic do_bit(logic v); pulse(0, 0, 1, v); wait_ready(); endtask
  task automatic do_stop(); pulse(0, 1, 0, 0); wait_ready(); steps(3); endtask

  initial begin
    // R1: reset and idle state
    cur_req = "R1";
    steps(4); rst_n = 1; steps(4);
    configure(0, 2, 4, 2, 1);
    steps(4);
    // R9: stop and bit are ignored while idle
    cur_req = "R9";
    pulse(0, 1, 0, 0); pulse(0, 0, 1, 1); steps(4);
    // R4: START from idle
    cur_req = "R4";
    do_start();
    // R5: bit slots of both values
    cur_req = "R5";
    do_bit(1); do_bit(0); do_bit(1);
    // R8: STOP
    cur_req = "R8";
    do_stop();
    // R7: repeated START
    cur_req = "R7";
    do_start(); do_bit(0); do_start(); do_bit(1); do_stop();
    // R6: clock stretching during the wait for SCL high
    cur_req = "R6";
    do_start();
    pulse(0, 0, 1, 1); stretch = 1; steps(20); stretch = 0; wait_ready();
    do_stop();
    // R9: priority and requests while busy
    cur_req = "R9";
    do_start();
    pulse(1, 1, 1, 0); step(); pulse(0, 1, 0, 0); wait_ready();
    pulse(0, 1, 1, 0); steps(2); pulse(1, 0, 0, 0); wait_ready(); steps(3);
    // R2: configuration changes while enabled have no effect
    cur_req = "R2";
    do_start();
    cfg_prescale = 3'd3; cfg_high = 6'd9; cfg_low = 6'd18; cfg_sethold = 6'd9; cfg_dvalid = 6'd4;
    do_bit(0); do_bit(1); do_stop();
    // R3: prescaled timing
    cur_req = "R3";
    configure(2, 3, 6, 3, 1);
    do_start(); do_bit(0); do_bit(1); do_stop();
    configure(7, 1, 3, 2, 1);
    do_start(); do_bit(1); do_stop();
    // R5: widest fields
    cur_req = "R5";
    configure(0, 31, 62, 31, 15);
    do_start(); do_bit(0); do_stop();
    // R10: abort by clearing enable mid-bit
    cur_req = "R10";
    configure(1, 2, 4, 2, 1);
    do_start();
    pulse(0, 0, 1, 0); steps(3);
    en = 0; steps(5); en = 1; steps(2);
    do_start(); do_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule